// File: doc/BRIEF.md
# Vertical-First Mesh Stop Router

This block is a single stop in a two-dimensional grid of tiles. It has five ports, each with its own valid/ready handshake: one for the local tile and one for each neighbour to the north, south, east and west. Packets come in on any port and leave on exactly one port. The destination row and column in each packet header choose that port. The stop always resolves the row first and only then the column. It takes the shorter way along each axis. A packet whose coordinates match the stop is handed to the local tile.

Rows and columns are open chains with no wraparound link. A stop on the grid edge therefore builds no output toward a neighbour that does not exist. A reply from B to A does its vertical leg in B's column, while the request from A to B did its vertical leg in A's column, so the two paths usually differ. Each output has a round-robin arbiter and one output register. A packet that names a coordinate outside the grid is taken in and discarded, and a sticky error flag records it.

Top module: `mesh_stop`

## Requirements
- R1: While synchronous active-high `rst` is held, and in the first cycle after it is released, every `out_valid` bit and `cfg_err` are 0.
- R2: A packet is `2*CW+PW` bits wide: the top CW bits hold the destination row, the next CW bits hold the destination column, and the low PW bits hold the payload. Port index 0 is local, 1 north, 2 south, 3 east, 4 west. Row 0 lies at the north edge and column 0 at the west edge. A packet whose destination row differs from MY_ROW leaves on a vertical port whatever its column.
- R3: A destination row below MY_ROW leaves on north (1). A destination row above MY_ROW leaves on south (2). This holds for packets entering on any input.
- R4: When the destination row equals MY_ROW, a destination column above MY_COL leaves on east (3) and a destination column below MY_COL leaves on west (4).
- R5: A packet whose row and column both equal the stop's own coordinates leaves on the local output (0).
- R6: A packet accepted at clock edge k is valid on its output right after edge k, with its bits unchanged. With every ready high, each accepted packet appears exactly once.
- R7: While an output shows valid and its ready is low, its valid and data hold steady. Another packet bound for that output is not accepted until the output drains.
- R8: Inputs that contend for the same output are served in round-robin order. When four inputs request one output continuously, any four consecutive grants go to four different inputs.
- R9: A packet whose row is at least ROWS or whose column is at least COLS is accepted in the cycle it is offered and never appears on any output. It sets `cfg_err`, which stays at 1 until reset.
- R10: On an edge stop, the outputs toward missing neighbours never assert valid. Packets at such a stop still route correctly through the directions that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Packet offered on each input port |
| in_data | input | 5 x (2*CW+PW) | Packet on each input port |
| in_ready | output | 5 | Input packet taken this cycle |
| out_valid | output | 5 | Output register holds a packet |
| out_data | output | 5 x (2*CW+PW) | Packet on each output port |
| out_ready | input | 5 | Downstream takes the output packet |
| cfg_err | output | 1 | Sticky: an out-of-grid destination was seen |

## Verification
Destinations in every relation to the stop are sent from several different inputs. Targets above, below and in the stop's own row, in a different column or the same one, show whether the row is settled before the column and whether the direction is chosen from the coordinates rather than from the arrival port. A stalled output, with a second packet behind it, shows that data holds and that the input is held off. Four inputs hammering one output expose the arbiter's rotation order. Out-of-grid rows and columns show the drop and the sticky flag. A second stop at the top-right corner shows that its missing north and east links stay silent while west and south traffic still flows.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

  // port numbering shared by route, arbitration and the top
  localparam int NP  = 5;
  localparam int P_L = 0;
  localparam int P_N = 1;
  localparam int P_S = 2;
  localparam int P_E = 3;
  localparam int P_W = 4;

  // outputs that exist for a stop at (r, c) in a rows x cols grid
  function automatic logic [NP-1:0] live_ports(int rows, int cols, int r, int c);
    logic [NP-1:0] m;
    m      = '0;
    m[P_L] = 1'b1;
    m[P_N] = (r > 0);
    m[P_S] = (r < rows - 1);
    m[P_E] = (c < cols - 1);
    m[P_W] = (c > 0);
    return m;
  endfunction

endpackage

// File: rtl/mesh_route.sv
module mesh_route
  import mesh_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int MY_ROW = 1,
  parameter int MY_COL = 1,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] col,
  output logic [NP-1:0] req,
  output logic          bad
);

  localparam int CX = CW + 1;
  localparam logic [CX-1:0] ROW_LIM = CX'(ROWS);
  localparam logic [CX-1:0] COL_LIM = CX'(COLS);
  localparam logic [CX-1:0] ROW_ME  = CX'(MY_ROW);
  localparam logic [CX-1:0] COL_ME  = CX'(MY_COL);
  localparam logic [NP-1:0] LIVE    = live_ports(ROWS, COLS, MY_ROW, MY_COL);

  logic [CX-1:0] r_x, c_x;

  assign r_x = {1'b0, row};
  assign c_x = {1'b0, col};

  always_comb begin
    bad = vld && ((r_x >= ROW_LIM) || (c_x >= COL_LIM));
    req = '0;
    if (vld && !bad) begin
      if (r_x < ROW_ME)      req[P_N] = 1'b1;
      else if (r_x > ROW_ME) req[P_S] = 1'b1;
      else if (c_x > COL_ME) req[P_E] = 1'b1;
      else if (c_x < COL_ME) req[P_W] = 1'b1;
      else                   req[P_L] = 1'b1;
    end
  end

  // R2
  one_dir_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(req));
  // R9
  bad_no_req_chk: assert property (@(posedge clk) disable iff (rst) bad |-> (req == '0));
  // R10
  no_dead_port_chk: assert property (@(posedge clk) disable iff (rst) (req & ~LIVE) == '0);

endmodule

// File: rtl/mesh_rr_arb.sv
module mesh_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);

  localparam int PTRW = (N > 1) ? $clog2(N) : 1;

  logic [PTRW-1:0] ptr, win;
  logic            found;

  always_comb begin
    int idx;
    gnt   = '0;
    found = 1'b0;
    win   = '0;
    for (int off = 0; off < N; off++) begin
      idx = (int'(ptr) + off) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        win      = PTRW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv && found)
      ptr <= (win == PTRW'(N - 1)) ? '0 : win + 1'b1;
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R8
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);

endmodule

// File: rtl/mesh_out_slot.sv
module mesh_out_slot #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)
      valid <= 1'b0;
    else if (load)
      valid <= 1'b1;
    else if (ready)
      valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load)
      dout <= din;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));
  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && valid && !ready));

endmodule

// File: rtl/mesh_stop.sv
module mesh_stop
  import mesh_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int MY_ROW = 1,
  parameter int MY_COL = 1,
  parameter int CW     = 3,
  parameter int PW     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NP-1:0]                  in_valid,
  input  logic [NP-1:0][2*CW+PW-1:0]     in_data,
  output logic [NP-1:0]                  in_ready,
  output logic [NP-1:0]                  out_valid,
  output logic [NP-1:0][2*CW+PW-1:0]     out_data,
  input  logic [NP-1:0]                  out_ready,
  output logic                           cfg_err
);

  localparam int FW = 2 * CW + PW;
  localparam logic [NP-1:0] LIVE = live_ports(ROWS, COLS, MY_ROW, MY_COL);

  logic [NP-1:0] rq   [NP];   // per input: requested output
  logic [NP-1:0] rq_t [NP];   // per output: requesting inputs
  logic [NP-1:0] gnt  [NP];   // per output: granted input
  logic [NP-1:0] take [NP];   // per input: output that takes it now
  logic [NP-1:0] bad;
  logic [NP-1:0] can_load;

  // route computation, one per input
  for (genvar i = 0; i < NP; i++) begin : g_in
    mesh_route #(
      .ROWS(ROWS), .COLS(COLS), .MY_ROW(MY_ROW), .MY_COL(MY_COL), .CW(CW)
    ) u_route (
      .clk (clk),
      .rst (rst),
      .vld (in_valid[i]),
      .row (in_data[i][FW-1 -: CW]),
      .col (in_data[i][FW-CW-1 -: CW]),
      .req (rq[i]),
      .bad (bad[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        rq_t[o][i] = rq[i][o];
  end

  // one arbiter and output register per existing direction
  for (genvar o = 0; o < NP; o++) begin : g_out
    if (LIVE[o]) begin : g_live
      logic [FW-1:0] sel;

      assign can_load[o] = !out_valid[o] || out_ready[o];

      mesh_rr_arb #(.N(NP)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (rq_t[o]),
        .adv (can_load[o]),
        .gnt (gnt[o])
      );

      always_comb begin
        sel = '0;
        for (int i = 0; i < NP; i++)
          if (gnt[o][i]) sel = sel | in_data[i];
      end

      mesh_out_slot #(.W(FW)) u_slot (
        .clk   (clk),
        .rst   (rst),
        .load  (can_load[o] && (gnt[o] != '0)),
        .din   (sel),
        .ready (out_ready[o]),
        .valid (out_valid[o]),
        .dout  (out_data[o])
      );
    end else begin : g_dead
      assign can_load[o]  = 1'b0;
      assign gnt[o]       = '0;
      assign out_valid[o] = 1'b0;
      assign out_data[o]  = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++)
        take[i][o] = gnt[o][i] && can_load[o];
      in_ready[i] = bad[i] || (take[i] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_err <= 1'b0;
    else if (bad != '0)
      cfg_err <= 1'b1;
  end

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst) (bad != '0) |=> cfg_err);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |=> cfg_err);

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R6
    single_take_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(take[i]));
  end

endmodule

// File: tb/tb_mesh_stop.sv
`timescale 1ns/1ps
module tb_mesh_stop;

  localparam int FW = 14;
  localparam int L = 0, N = 1, S = 2, E = 3, W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [4:0]         in_valid, in_ready, out_valid, out_ready;
  logic [4:0][FW-1:0] in_data, out_data;
  logic               cfg_err;

  logic [4:0]         e_in_valid, e_in_ready, e_out_valid, e_out_ready;
  logic [4:0][FW-1:0] e_in_data, e_out_data;
  logic               e_cfg_err;

  mesh_stop #(.ROWS(4), .COLS(4), .MY_ROW(1), .MY_COL(1), .CW(3), .PW(8)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .cfg_err(cfg_err));

  mesh_stop #(.ROWS(4), .COLS(4), .MY_ROW(0), .MY_COL(3), .CW(3), .PW(8)) dut_edge (
    .clk(clk), .rst(rst), .in_valid(e_in_valid), .in_data(e_in_data), .in_ready(e_in_ready),
    .out_valid(e_out_valid), .out_data(e_out_data), .out_ready(e_out_ready), .cfg_err(e_cfg_err));

  int n_run = 0;
  int n_fail = 0;
  int edge_bad = 0;
  logic [FW-1:0] expq [5][$];
  string         tagq [5][$];
  logic [7:0]    nlog [$];

  function automatic logic [FW-1:0] pk(int r, int c, logic [7:0] pay);
    return {3'(r), 3'(c), pay};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: call at a falling edge; returns at the falling edge after acceptance
  task automatic send(int p, logic [FW-1:0] d, int op, string tag, bit hold);
    in_valid[p] = 1'b1;
    in_data[p]  = d;
    forever begin
      #1;
      if (in_ready[p]) break;
      @(negedge clk);
    end
    if (op >= 0) begin
      expq[op].push_back(d);
      tagq[op].push_back(tag);
    end
    @(negedge clk);
    if (!hold) in_valid[p] = 1'b0;
  endtask

  // monitor: scoreboard match of every output beat
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        for (int p = 0; p < 5; p++) begin
          if (out_valid[p] && out_ready[p]) begin
            int hit;
            hit = -1;
            for (int k = 0; k < expq[p].size(); k++)
              if (hit < 0 && expq[p][k] == out_data[p]) hit = k;
            n_run++;
            if (hit >= 0) begin
              if (p == N) nlog.push_back(out_data[p][7:0]);
              expq[p].delete(hit);
              tagq[p].delete(hit);
            end else begin
              string t;
              t = "R9";
              for (int q = 0; q < 5; q++)
                for (int k = 0; k < expq[q].size(); k++)
                  if (expq[q][k] == out_data[p]) t = tagq[q][k];
              n_fail++;
              $display("FAIL %s unexpected packet on port %0d actual=%0h expected=none",
                       t, p, out_data[p]);
            end
          end
        end
        if (e_out_valid[N] || e_out_valid[E]) edge_bad++;
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    in_valid = '0; in_data = '0; out_ready = '1;
    e_in_valid = '0; e_in_data = '0; e_out_ready = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", out_valid, 5'b0);
    chk("R1", cfg_err, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", out_valid, 5'b0);
    chk("R1", e_out_valid, 5'b0);
    chk("R1", cfg_err, 1'b0);
    @(negedge clk);

    // R5: own coordinates, arriving from the north neighbour
    send(N, pk(1, 1, 8'h11), L, "R5", 0);
    send(E, pk(1, 1, 8'h12), L, "R5", 0);
    // R2: vertical leg first even when the column differs
    send(L, pk(3, 3, 8'h21), S, "R2", 0);
    send(L, pk(0, 0, 8'h22), N, "R2", 0);
    send(W, pk(2, 3, 8'h23), S, "R2", 0);
    // R3: direction by row, from neighbour inputs
    send(E, pk(0, 3, 8'h31), N, "R3", 0);
    send(W, pk(2, 0, 8'h32), S, "R3", 0);
    // R4: same row, direction by column
    send(S, pk(1, 3, 8'h41), E, "R4", 0);
    send(L, pk(1, 0, 8'h42), W, "R4", 0);
    send(N, pk(1, 2, 8'h43), E, "R4", 0);

    // R6: one-cycle latency, exactly one copy
    repeat (2) @(negedge clk);
    send(L, pk(1, 2, 8'h61), E, "R6", 0);
    #1;
    chk("R6", out_valid[E], 1'b1);
    chk("R6", out_data[E], pk(1, 2, 8'h61));
    @(negedge clk);
    #1;
    chk("R6", out_valid[E], 1'b0);
    @(negedge clk);

    // R7: stalled output holds, second packet is held off
    out_ready[S] = 1'b0;
    send(L, pk(3, 1, 8'h71), S, "R7", 0);
    in_valid[L] = 1'b1;
    in_data[L]  = pk(2, 1, 8'h72);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7", in_ready[L], 1'b0);
      chk("R7", out_valid[S], 1'b1);
      chk("R7", out_data[S], pk(3, 1, 8'h71));
      @(negedge clk);
    end
    out_ready[S] = 1'b1;
    #1;
    chk("R7", in_ready[L], 1'b1);
    expq[S].push_back(pk(2, 1, 8'h72));
    tagq[S].push_back("R7");
    @(negedge clk);
    in_valid[L] = 1'b0;
    repeat (3) @(negedge clk);

    // R8: four inputs contend for north
    nlog.delete();
    fork
      for (int k = 0; k < 3; k++) send(L, pk(0, 1, {4'd0, 4'(k)}), N, "R8", k < 2);
      for (int k = 0; k < 3; k++) send(S, pk(0, 1, {4'd2, 4'(k)}), N, "R8", k < 2);
      for (int k = 0; k < 3; k++) send(E, pk(0, 2, {4'd3, 4'(k)}), N, "R8", k < 2);
      for (int k = 0; k < 3; k++) send(W, pk(0, 0, {4'd4, 4'(k)}), N, "R8", k < 2);
    join
    repeat (3) @(negedge clk);
    chk("R8", nlog.size(), 12);
    begin
      int viol;
      viol = 0;
      for (int k = 0; k + 3 < nlog.size(); k++)
        for (int a = 0; a < 4; a++)
          for (int b = a + 1; b < 4; b++)
            if (nlog[k+a][7:4] == nlog[k+b][7:4]) viol++;
      chk("R8", viol, 0);
    end

    // R9: out-of-grid row and column
    chk("R9", cfg_err, 1'b0);
    send(L, pk(5, 0, 8'h91), -1, "R9", 0);
    #1;
    chk("R9", cfg_err, 1'b1);
    chk("R9", out_valid, 5'b0);
    @(negedge clk);
    send(N, pk(1, 4, 8'h92), -1, "R9", 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9", out_valid, 5'b0);
      @(negedge clk);
    end
    send(L, pk(1, 1, 8'h93), L, "R9", 0);
    #1;
    chk("R9", cfg_err, 1'b1);
    @(negedge clk);

    // R10: corner stop at row 0, last column
    e_in_valid[L] = 1'b1;
    e_in_data[L]  = pk(0, 0, 8'hA1);
    #1;
    chk("R10", e_in_ready[L], 1'b1);
    @(negedge clk);
    e_in_valid[L] = 1'b0;
    #1;
    chk("R10", e_out_valid[W], 1'b1);
    chk("R10", e_out_data[W], pk(0, 0, 8'hA1));
    @(negedge clk);
    e_in_valid[W] = 1'b1;
    e_in_data[W]  = pk(2, 3, 8'hA2);
    #1;
    chk("R10", e_in_ready[W], 1'b1);
    @(negedge clk);
    e_in_valid[W] = 1'b0;
    #1;
    chk("R10", e_out_valid[S], 1'b1);
    chk("R10", e_out_data[S], pk(2, 3, 8'hA2));
    @(negedge clk);
    chk("R10", edge_bad, 0);

    repeat (5) @(negedge clk);
    for (int p = 0; p < 5; p++) chk("R6", expq[p].size(), 0);
    finish_run();
  end

endmodule